// File: doc/BRIEF.md
# Hot-Plug Slot Command Processor

This block runs the command engine of a hot-plug controller. Software writes a command byte and a target byte. Either write starts one command. The block then updates a bank of per-slot records. Each slot keeps a 2-bit state, a 2-bit power indicator, a 2-bit attention indicator, a latch-open flag, a 2-bit presence field and three sticky event bits. The engine also handles three other kinds of command: a secondary bus speed command, two broadcast commands that walk every slot, and all remaining codes, which it rejects.

Each command reports its result through invalid-command and invalid-mode status bits, a one-cycle completion pulse and a sticky command-detected flag. A slot that is disabled while its power indicator is off releases its card. It then reads as empty with its latch open, latches its events and raises a one-cycle removal request. The reset contents of each slot follow a parameter that marks which slots hold a card at power-up. An occupied slot starts enabled, with its power indicator on, its latch closed and presence 0. An empty slot starts disabled, with its power indicator off, its latch open and presence 3.

Top module: `hp_slot_cmd_proc`

## Requirements
- R1: A command code below 0x40 is a slot command. Code bits [5:4] carry the attention indicator request and bits [3:2] the power indicator request (0 keep, 1 on, 2 blink, 3 off). A nonzero request overwrites that indicator of the target slot whenever the command is not refused.
- R2: Only the low 5 bits of the target byte are kept. Target n selects slot n-1. A target of 0, or a target above the slot count, sets the invalid-command bit and changes no slot.
- R3: Code bits [1:0] request a state (0 keep, 1 power-only, 2 enabled, 3 disabled). From enabled, a power-only request is refused: it sets invalid-command and writes nothing. The state only changes disabled to power-only, disabled to enabled, or enabled/power-only to disabled; every other request leaves the state as it is.
- R4: A move to disabled in which the power indicator, after any update by the same command, reads off does the following: it sets the latch-open flag, sets presence to 3, sets the button, latch and presence event bits, and pulses the removal request of that slot for one cycle.
- R5: Codes 0x40 to 0x47 are speed commands. A low field of 0 keeps bus_speed at 0 and is accepted. Any other value sets invalid-mode.
- R6: Codes 0x48 (all power-only) and 0x49 (all enabled) are refused with invalid-command when any slot is enabled, and then no slot changes.
- R7: An accepted broadcast walks the slots from index 0 upwards, one per clock. A slot with its latch closed receives the broadcast state with its power indicator on. A slot with its latch open receives "keep" with its power indicator off.
- R8: Every other code sets invalid-command. Starting a command clears both status bits.
- R9: Every command ends with a one-cycle done pulse and sets cmd_detected, which holds until det_clr.
- R10: A write to either byte while idle starts one command, using the stored value of the byte that was not written. busy is high until completion. Writes that arrive while busy are ignored.
- R11: After reset, each slot holds the contents set by RESET_OCCUPIED, both status bits and cmd_detected are 0, and bus_speed is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_code | input | 1 | Write strobe for the command byte |
| code_wdata | input | 8 | Command byte data |
| wr_tgt | input | 1 | Write strobe for the target byte |
| tgt_wdata | input | 8 | Target byte data |
| det_clr | input | 1 | Clears cmd_detected |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_detected | output | 1 | Sticky completion flag |
| inv_cmd | output | 1 | Last command was invalid |
| inv_mode | output | 1 | Last speed command asked for an unsupported speed |
| bus_speed | output | 3 | Secondary bus speed code |
| slot_state | output | 2*N_SLOTS | Per-slot state, slot i at bits [2i+1:2i] |
| pwr_led | output | 2*N_SLOTS | Per-slot power indicator |
| attn_led | output | 2*N_SLOTS | Per-slot attention indicator |
| mrl_open | output | N_SLOTS | Per-slot latch-open flag |
| presence | output | 2*N_SLOTS | Per-slot presence field |
| evt_button | output | N_SLOTS | Sticky button event |
| evt_mrl | output | N_SLOTS | Sticky latch event |
| evt_presence | output | N_SLOTS | Sticky presence event |
| rmv_req | output | N_SLOTS | One-cycle removal request |

## Verification
Let k be the edge that samples a write strobe. A slot, speed, refused-broadcast or invalid command updates its slot and status results at edge k+1 and shows done in the cycle after that edge. The removal pulse of a slot command appears in that same cycle. An accepted broadcast updates slot i at edge k+2+i and ends at edge k+1+N_SLOTS. The driver works out this due cycle for each command and stores it in the scoreboard item together with the predicted slot records. The monitor samples on falling edges, and whenever done is high it compares both the cycle count and every field. A done with no pending item is reported as a stray completion, and this is how a write accepted while busy shows up.

// File: rtl/hpsc_pkg.sv
package hpsc_pkg;

  typedef enum logic [1:0] {
    ST_KEEP = 2'd0,
    ST_PWR  = 2'd1,
    ST_ENA  = 2'd2,
    ST_DIS  = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    LED_KEEP  = 2'd0,
    LED_ON    = 2'd1,
    LED_BLINK = 2'd2,
    LED_OFF   = 2'd3
  } led_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_EXEC,
    PH_LOOP
  } phase_e;

  localparam logic [1:0] PRS_EMPTY = 2'd3;
  localparam logic [1:0] PRS_CARD  = 2'd0;
  localparam logic [2:0] SPEED_33  = 3'd0;

  typedef struct packed {
    slot_st_e st;
    led_e     pwr;
    led_e     attn;
  } slot_req_t;

  typedef struct packed {
    slot_st_e st;
    led_e     pwr;
    led_e     attn;
    logic     rmv;
  } slot_step_t;

  function automatic slot_req_t split_code(input logic [7:0] c);
    slot_req_t r;
    r.st   = slot_st_e'(c[1:0]);
    r.pwr  = led_e'(c[3:2]);
    r.attn = led_e'(c[5:4]);
    return r;
  endfunction

  function automatic logic tgt_in_range(input logic [4:0] t, input int n);
    return (t != 5'd0) && (int'(t) <= n);
  endfunction

  function automatic logic refused(input slot_st_e cur, input slot_st_e req);
    return (cur == ST_ENA) && (req == ST_PWR);
  endfunction

  function automatic logic moves(input slot_st_e cur, input slot_st_e req);
    logic up;
    logic down;
    up   = (cur == ST_DIS) && ((req == ST_PWR) || (req == ST_ENA));
    down = ((cur == ST_ENA) || (cur == ST_PWR)) && (req == ST_DIS);
    return up || down;
  endfunction

  function automatic slot_step_t step(input slot_st_e st, input led_e pwr,
                                      input led_e attn, input slot_req_t q);
    slot_step_t r;
    r.pwr  = (q.pwr  == LED_KEEP) ? pwr  : q.pwr;
    r.attn = (q.attn == LED_KEEP) ? attn : q.attn;
    r.st   = st;
    r.rmv  = 1'b0;
    if (moves(st, q.st)) begin
      r.st  = q.st;
      r.rmv = (q.st == ST_DIS) && (r.pwr == LED_OFF);
    end
    return r;
  endfunction

endpackage

// File: rtl/hpsc_slot.sv
module hpsc_slot
  import hpsc_pkg::*;
#(
  parameter bit OCC = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      apply,
  input  slot_req_t req,
  output slot_st_e  st,
  output led_e      pwr,
  output led_e      attn,
  output logic      mrl_open,
  output logic [1:0] prs,
  output logic      ev_btn,
  output logic      ev_mrl,
  output logic      ev_prs,
  output logic      rmv
);

  slot_step_t nxt;
  assign nxt = step(st, pwr, attn, req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= OCC ? ST_ENA : ST_DIS;
      pwr      <= OCC ? LED_ON : LED_OFF;
      attn     <= LED_KEEP;
      mrl_open <= !OCC;
      prs      <= OCC ? PRS_CARD : PRS_EMPTY;
      ev_btn   <= 1'b0;
      ev_mrl   <= 1'b0;
      ev_prs   <= 1'b0;
      rmv      <= 1'b0;
    end else begin
      rmv <= 1'b0;
      if (apply) begin
        st   <= nxt.st;
        pwr  <= nxt.pwr;
        attn <= nxt.attn;
        if (nxt.rmv) begin
          mrl_open <= 1'b1;
          prs      <= PRS_EMPTY;
          ev_btn   <= 1'b1;
          ev_mrl   <= 1'b1;
          ev_prs   <= 1'b1;
          rmv      <= 1'b1;
        end
      end
    end
  end

  // R4
  rmv_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmv |-> (st == ST_DIS) && (pwr == LED_OFF) && mrl_open && (prs == PRS_EMPTY)
            && ev_btn && ev_mrl && ev_prs);

  // R3
  legal_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |->
      (($past(st) == ST_DIS) && ((st == ST_PWR) || (st == ST_ENA))) ||
      ((($past(st) == ST_ENA) || ($past(st) == ST_PWR)) && (st == ST_DIS)));

  // R4
  rmv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmv |=> !rmv);

endmodule

// File: rtl/hpsc_ctrl.sv
module hpsc_ctrl
  import hpsc_pkg::*;
#(
  parameter int N_SLOTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_code,
  input  logic [7:0]         code_d,
  input  logic               wr_tgt,
  input  logic [7:0]         tgt_d,
  input  logic               det_clr,
  input  slot_st_e           slot_st [N_SLOTS],
  input  logic [N_SLOTS-1:0] mrl_open,
  output logic [N_SLOTS-1:0] apply,
  output slot_req_t          req,
  output logic               busy,
  output logic               done,
  output logic               detected,
  output logic               inv_cmd,
  output logic               inv_mode,
  output logic [2:0]         bus_speed
);

  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

  phase_e           ph;
  logic [7:0]       code_q;
  logic [4:0]       tgt_q;
  logic [IDX_W-1:0] idx;
  slot_st_e         bc_st;

  logic unused_tgt_hi;
  assign unused_tgt_hi = ^tgt_d[7:5];

  logic start;
  assign start = (wr_code | wr_tgt) & (ph == PH_IDLE);
  assign busy  = (ph != PH_IDLE);

  slot_req_t one_req;
  assign one_req = split_code(code_q);

  logic is_slot, is_speed, is_bcast;
  assign is_slot  = (code_q[7:6] == 2'b00);
  assign is_speed = (code_q[7:3] == 5'b01000);
  assign is_bcast = (code_q[7:1] == 7'b0100100);

  logic tgt_ok;
  assign tgt_ok = tgt_in_range(tgt_q, N_SLOTS);

  slot_st_e tgt_st;
  logic     any_ena;
  logic     bc_mrl;
  always_comb begin
    tgt_st  = ST_KEEP;
    any_ena = 1'b0;
    bc_mrl  = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (tgt_q == 5'(i + 1)) tgt_st = slot_st[i];
      if (slot_st[i] == ST_ENA) any_ena = 1'b1;
      if (idx == IDX_W'(i)) bc_mrl = mrl_open[i];
    end
  end

  logic one_ok;
  assign one_ok = is_slot && tgt_ok && !refused(tgt_st, one_req.st);

  logic bc_go;
  assign bc_go = is_bcast && !any_ena;

  always_comb begin
    if (ph == PH_LOOP) begin
      if (bc_mrl) req = '{st: ST_KEEP, pwr: LED_OFF, attn: LED_KEEP};
      else        req = '{st: bc_st,   pwr: LED_ON,  attn: LED_KEEP};
    end else begin
      req = one_req;
    end
    for (int i = 0; i < N_SLOTS; i++) begin
      apply[i] = ((ph == PH_EXEC) && one_ok && (tgt_q == 5'(i + 1))) ||
                 ((ph == PH_LOOP) && (idx == IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      code_q    <= 8'd0;
      tgt_q     <= 5'd0;
      idx       <= '0;
      bc_st     <= ST_KEEP;
      inv_cmd   <= 1'b0;
      inv_mode  <= 1'b0;
      bus_speed <= SPEED_33;
      done      <= 1'b0;
      detected  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (det_clr) detected <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            if (wr_code) code_q <= code_d;
            if (wr_tgt)  tgt_q  <= tgt_d[4:0];
            inv_cmd  <= 1'b0;
            inv_mode <= 1'b0;
            ph       <= PH_EXEC;
          end
        end
        PH_EXEC: begin
          ph <= PH_IDLE;
          if (is_slot) begin
            if (!one_ok) inv_cmd <= 1'b1;
          end else if (is_speed) begin
            if (code_q[2:0] == SPEED_33) bus_speed <= code_q[2:0];
            else inv_mode <= 1'b1;
          end else if (is_bcast) begin
            if (any_ena) begin
              inv_cmd <= 1'b1;
            end else begin
              ph    <= PH_LOOP;
              idx   <= '0;
              bc_st <= code_q[0] ? ST_ENA : ST_PWR;
            end
          end else begin
            inv_cmd <= 1'b1;
          end
          if (!bc_go) begin
            done     <= 1'b1;
            detected <= 1'b1;
          end
        end
        PH_LOOP: begin
          if (idx == LAST) begin
            ph       <= PH_IDLE;
            done     <= 1'b1;
            detected <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R7
  apply_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(apply));

  // R10
  apply_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|apply) |-> busy);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> detected);

  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_code || wr_tgt)) |=> ($stable(code_q) && $stable(tgt_q)));

  // R5
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_mode |-> (bus_speed == SPEED_33));

endmodule

// File: rtl/hp_slot_cmd_proc.sv
module hp_slot_cmd_proc
  import hpsc_pkg::*;
#(
  parameter int          N_SLOTS        = 8,
  parameter logic [30:0] RESET_OCCUPIED = 31'h0000_0055
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_code,
  input  logic [7:0]           code_wdata,
  input  logic                 wr_tgt,
  input  logic [7:0]           tgt_wdata,
  input  logic                 det_clr,
  output logic                 busy,
  output logic                 done,
  output logic                 cmd_detected,
  output logic                 inv_cmd,
  output logic                 inv_mode,
  output logic [2:0]           bus_speed,
  output logic [2*N_SLOTS-1:0] slot_state,
  output logic [2*N_SLOTS-1:0] pwr_led,
  output logic [2*N_SLOTS-1:0] attn_led,
  output logic [N_SLOTS-1:0]   mrl_open,
  output logic [2*N_SLOTS-1:0] presence,
  output logic [N_SLOTS-1:0]   evt_button,
  output logic [N_SLOTS-1:0]   evt_mrl,
  output logic [N_SLOTS-1:0]   evt_presence,
  output logic [N_SLOTS-1:0]   rmv_req
);

  slot_st_e           st_w   [N_SLOTS];
  led_e               pwr_w  [N_SLOTS];
  led_e               attn_w [N_SLOTS];
  logic [N_SLOTS-1:0] apply_w;
  slot_req_t          req_w;

  hpsc_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_code   (wr_code),
    .code_d    (code_wdata),
    .wr_tgt    (wr_tgt),
    .tgt_d     (tgt_wdata),
    .det_clr   (det_clr),
    .slot_st   (st_w),
    .mrl_open  (mrl_open),
    .apply     (apply_w),
    .req       (req_w),
    .busy      (busy),
    .done      (done),
    .detected  (cmd_detected),
    .inv_cmd   (inv_cmd),
    .inv_mode  (inv_mode),
    .bus_speed (bus_speed)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    hpsc_slot #(.OCC(RESET_OCCUPIED[g])) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .apply    (apply_w[g]),
      .req      (req_w),
      .st       (st_w[g]),
      .pwr      (pwr_w[g]),
      .attn     (attn_w[g]),
      .mrl_open (mrl_open[g]),
      .prs      (presence[2*g +: 2]),
      .ev_btn   (evt_button[g]),
      .ev_mrl   (evt_mrl[g]),
      .ev_prs   (evt_presence[g]),
      .rmv      (rmv_req[g])
    );
    assign slot_state[2*g +: 2] = st_w[g];
    assign pwr_led[2*g +: 2]    = pwr_w[g];
    assign attn_led[2*g +: 2]   = attn_w[g];
  end

endmodule

// File: tb/hp_slot_cmd_proc_tb.sv
module hp_slot_cmd_proc_tb;

  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_code = 1'b0, wr_tgt = 1'b0, det_clr = 1'b0;
  logic [7:0] code_wdata = 8'd0, tgt_wdata = 8'd0;
  logic busy, done, cmd_detected, inv_cmd, inv_mode;
  logic [2:0] bus_speed;
  logic [2*NS-1:0] slot_state, pwr_led, attn_led, presence;
  logic [NS-1:0] mrl_open, evt_button, evt_mrl, evt_presence, rmv_req;

  always #4 clk = ~clk;

  hp_slot_cmd_proc #(.N_SLOTS(NS), .RESET_OCCUPIED(31'h5)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_code(wr_code), .code_wdata(code_wdata),
    .wr_tgt(wr_tgt), .tgt_wdata(tgt_wdata), .det_clr(det_clr),
    .busy(busy), .done(done), .cmd_detected(cmd_detected),
    .inv_cmd(inv_cmd), .inv_mode(inv_mode), .bus_speed(bus_speed),
    .slot_state(slot_state), .pwr_led(pwr_led), .attn_led(attn_led),
    .mrl_open(mrl_open), .presence(presence), .evt_button(evt_button),
    .evt_mrl(evt_mrl), .evt_presence(evt_presence), .rmv_req(rmv_req)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model of the slot bank
  int ms[NS], mp[NS], ma[NS], mm[NS], mpr[NS], eb[NS], em[NS], ep[NS], mrmv[NS];
  logic [7:0] held_code = 8'd0;
  logic [7:0] held_tgt  = 8'd0;

  typedef struct {
    string tag;
    int due;
    logic [2*NS-1:0] st, pw, at, pr;
    logic [NS-1:0] mrl, ev, rmv;
    logic ic, im;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic m_apply(input int i, input int rq, input int pl, input int al);
    if (pl != 0) mp[i] = pl;
    if (al != 0) ma[i] = al;
    if ((ms[i] == 3 && (rq == 1 || rq == 2)) || ((ms[i] == 1 || ms[i] == 2) && rq == 3)) begin
      ms[i] = rq;
      if (rq == 3 && mp[i] == 3) begin
        mm[i] = 1; mpr[i] = 3; eb[i] = 1; em[i] = 1; ep[i] = 1; mrmv[i] = 1;
      end
    end
  endtask

  task automatic m_cmd(input int code, input int tgt, output bit ic, output bit im, output bit bc);
    bit any;
    ic = 0; im = 0; bc = 0; any = 0;
    if (code < 64) begin
      if (tgt == 0 || tgt > NS) ic = 1;
      else if (ms[tgt-1] == 2 && (code & 3) == 1) ic = 1;
      else m_apply(tgt - 1, code & 3, (code >> 2) & 3, (code >> 4) & 3);
    end else if (code <= 71) begin
      im = ((code & 7) != 0);
    end else if (code == 72 || code == 73) begin
      for (int i = 0; i < NS; i++) if (ms[i] == 2) any = 1;
      if (any) ic = 1;
      else begin
        bc = 1;
        for (int i = 0; i < NS; i++) begin
          if (mm[i] == 0) m_apply(i, (code == 73) ? 2 : 1, 1, 0);
          else m_apply(i, 0, 3, 0);
        end
      end
    end else begin
      ic = 1;
    end
  endtask

  function automatic exp_t snap(input string tag, input int due, input bit ic, input bit im);
    exp_t e;
    e.tag = tag; e.due = due; e.ic = ic; e.im = im;
    for (int i = 0; i < NS; i++) begin
      e.st[2*i +: 2] = 2'(ms[i]);
      e.pw[2*i +: 2] = 2'(mp[i]);
      e.at[2*i +: 2] = 2'(ma[i]);
      e.pr[2*i +: 2] = 2'(mpr[i]);
      e.mrl[i] = mm[i][0];
      e.ev[i]  = (eb[i] & em[i] & ep[i]) != 0;
      e.rmv[i] = mrmv[i][0];
    end
    return e;
  endfunction

  task automatic compare_fields(input exp_t e);
    logic [NS-1:0] ev_all;
    ev_all = evt_button & evt_mrl & evt_presence;
    check(e.tag, "slot_state", int'(slot_state), int'(e.st));
    check(e.tag, "pwr_led", int'(pwr_led), int'(e.pw));
    check(e.tag, "attn_led", int'(attn_led), int'(e.at));
    check(e.tag, "presence", int'(presence), int'(e.pr));
    check(e.tag, "mrl_open", int'(mrl_open), int'(e.mrl));
    check(e.tag, "events", int'(ev_all), int'(e.ev));
    check(e.tag, "event_mix", int'(evt_button ^ evt_mrl ^ evt_presence), int'(e.ev));
  endtask

  // monitor: pops one item per completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 stray completion: actual done=1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "latency cycle", cyc, e.due);
        compare_fields(e);
        check(e.tag, "rmv_req", int'(rmv_req), int'(e.rmv));
        check(e.tag, "inv_cmd R8", int'(inv_cmd), int'(e.ic));
        check(e.tag, "inv_mode R5", int'(inv_mode), int'(e.im));
        check(e.tag, "cmd_detected R9", int'(cmd_detected), 1);
        check(e.tag, "bus_speed R5", int'(bus_speed), 0);
      end
    end
  end

  task automatic issue(input bit wc, input bit wt, input logic [7:0] c, input logic [7:0] t,
                       input string tag, input bit poke = 1'b0);
    bit ic, im, bc;
    int due;
    @(negedge clk);
    wr_code = wc; wr_tgt = wt; code_wdata = c; tgt_wdata = t;
    if (wc) held_code = c;
    if (wt) held_tgt = t & 8'h1f;
    for (int i = 0; i < NS; i++) mrmv[i] = 0;
    m_cmd(int'(held_code), int'(held_tgt), ic, im, bc);
    due = cyc + 2 + (bc ? NS : 0);
    exp_q.push_back(snap(tag, due, ic, im));
    @(negedge clk);
    wr_code = 1'b0; wr_tgt = 1'b0;
    check(tag, "busy during command R10", int'(busy), 1);
    if (poke) begin
      wr_code = 1'b1; wr_tgt = 1'b1; code_wdata = 8'h03; tgt_wdata = 8'h03;
      @(negedge clk);
      wr_code = 1'b0; wr_tgt = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(tag, "busy after completion R10", int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      ms[i]  = (i % 2 == 0) ? 2 : 3;
      mp[i]  = (i % 2 == 0) ? 1 : 3;
      ma[i]  = 0;
      mm[i]  = (i % 2 == 0) ? 0 : 1;
      mpr[i] = (i % 2 == 0) ? 0 : 3;
      eb[i] = 0; em[i] = 0; ep[i] = 0; mrmv[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset contents
    compare_fields(snap("R11", 0, 0, 0));
    check("R11", "inv_cmd", int'(inv_cmd), 0);
    check("R11", "cmd_detected", int'(cmd_detected), 0);
    check("R11", "busy", int'(busy), 0);
    check("R11", "bus_speed", int'(bus_speed), 0);

    issue(1, 1, 8'h00, 8'h00, "R2");          // target 0
    issue(1, 1, 8'h00, 8'h05, "R2");          // above slot count
    issue(1, 1, 8'h10, 8'h24, "R2");          // masked to target 4, attn on
    issue(1, 1, 8'h05, 8'h01, "R3");          // enabled -> power-only refused
    issue(1, 1, 8'h20, 8'h02, "R1");          // attention blink
    issue(0, 1, 8'h00, 8'h04, "R10");         // target only, reuses code 0x20
    issue(1, 1, 8'h03, 8'h01, "R3");          // disable, power on: no removal
    issue(1, 1, 8'h0C, 8'h01, "R1");          // power indicator off
    issue(1, 1, 8'h03, 8'h01, "R3");          // disabled -> disabled: no change
    issue(1, 1, 8'h02, 8'h01, "R3");          // enable
    issue(1, 1, 8'h0F, 8'h01, "R4");          // off + disable: removal
    issue(1, 1, 8'h40, 8'h00, "R5");
    issue(1, 1, 8'h41, 8'h00, "R5");
    issue(1, 1, 8'h47, 8'h00, "R5");
    issue(1, 1, 8'h4A, 8'h00, "R8");
    issue(1, 1, 8'h80, 8'h00, "R8");
    issue(1, 1, 8'hFF, 8'h00, "R8");
    issue(1, 1, 8'h49, 8'h00, "R6");          // slot 2 still enabled
    issue(1, 1, 8'h03, 8'h03, "R3");          // disable slot 2
    issue(1, 1, 8'h49, 8'h00, "R7", 1'b1);    // enable all, with a write while busy
    compare_fields(snap("R10", 0, 0, 0));
    issue(1, 1, 8'h48, 8'h00, "R6");          // refused: slot 2 enabled
    issue(1, 1, 8'h03, 8'h03, "R3");
    issue(1, 1, 8'h48, 8'h00, "R7");          // power-only all
    issue(1, 1, 8'h01, 8'h03, "R3");          // power-only -> power-only
    issue(1, 1, 8'h0F, 8'h03, "R4");          // removal from power-only

    @(negedge clk);
    check("R9", "cmd_detected before clear", int'(cmd_detected), 1);
    det_clr = 1'b1;
    @(negedge clk);
    det_clr = 1'b0;
    check("R9", "cmd_detected after clear", int'(cmd_detected), 0);
    repeat (2) @(negedge clk);
    check("R9", "done idle", int'(done), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule